// File: doc/BRIEF.md
# High-Voltage Serial Instruction Shifter

This block drives a programming target over three output lines and one input line. The outputs are a slow serial clock, a serial data line and a serial instruction line. The input carries the bits the target returns. A host-side command is either a raw transfer of one data/instruction byte pair, or a memory read. A memory read is a chain of three such pairs, built inside the block, that fetches one identification byte or the oscillator calibration byte. Both outgoing streams leave together, MSB first, framed by a start bit and two stop bits, on the one generated clock. The returned byte is taken from the target line on rising clock edges.

For a memory read the target has not yet decoded anything during the first two frames. The block therefore throws away what it samples there and reports only what it samples in the final frame. The serial clock period comes from a parameterised divider, so slow or noisy targets can be run at a lower bit rate without any change to the framing. The host sees a busy flag while a command is running, a one-cycle done pulse, and a result register.

Top module: `hv_serial_shifter`

## Requirements
- R1: After reset, ser_clk, ser_data, ser_instr, busy and done are all 0, and rdata is 0x00.
- R2: Every frame lasts 11 serial clock periods. On both ser_data and ser_instr the bits are: one start bit 0, then the eight bits of the byte MSB first, then two stop bits 0.
- R3: ser_data and ser_instr change only together with a falling edge of ser_clk. They are unchanged on every rising edge.
- R4: Within a frame ser_clk is high for HALF_DIV and low for HALF_DIV system cycles per bit. It stays low whenever no frame is being shifted. A single-frame command keeps busy high for 22·HALF_DIV+2 cycles.
- R5: ser_rdbk is sampled at each rising edge of ser_clk. The first eight samples of a frame, first sample as MSB, form that frame's returned byte.
- R6: cmd_op = 2'b01 (identification read) sends three frames as (data, instruction) pairs: (0x08, 0x4C), then ({6'b0, cmd_addr}, 0x0C), then (0x00, 0x68).
- R7: cmd_op = 2'b10 (calibration read) sends (0x08, 0x4C), then (0x00, 0x0C), then (0x00, 0x78). The final instruction differs from R6 only in bit 4, the high/low byte selector.
- R8: For a three-frame read, rdata equals the byte returned in the third frame. Bytes returned in the first two frames have no effect on rdata.
- R9: busy is 1 in the cycle after cmd_valid is accepted. done is a single-cycle pulse, and busy is 0 in the cycle done is 1. rdata changes only with done.
- R10: cmd_valid while busy is ignored: no extra frame is sent and the running command's result is unchanged.
- R11: cmd_op = 2'b00 or 2'b11 sends one frame carrying cmd_data on ser_data and cmd_instr on ser_instr, and returns that frame's byte in rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_op | input | 2 | 00/11 raw frame, 01 identification read, 10 calibration read |
| cmd_addr | input | 2 | Identification byte index for reads |
| cmd_data | input | 8 | Data byte for a raw frame |
| cmd_instr | input | 8 | Instruction byte for a raw frame |
| ser_rdbk | input | 1 | Serial bit returned by the target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Returned byte, updated with done |
| ser_clk | output | 1 | Generated serial clock, idles low |
| ser_data | output | 1 | Serial data stream to target |
| ser_instr | output | 1 | Serial instruction stream to target |

## Verification
The bench builds the block with HALF_DIV = 2 rather than the default 8. This keeps each 11-bit frame to 44 system cycles, so every read sequence, the busy-window length and the count of high clock cycles can be checked exactly in a short run. A small target model in the bench returns a different byte in each frame. This makes it possible to see whether the result comes from the final frame and not from an earlier one. It also records both outgoing streams bit by bit, so the framing and the instruction bytes of all three read types can be compared against R6 and R7.

// File: rtl/hvs_pkg.sv
package hvs_pkg;

  typedef enum logic [1:0] {
    OP_RAW  = 2'b00,
    OP_SIG  = 2'b01,
    OP_CAL  = 2'b10,
    OP_RSV  = 2'b11
  } hvs_op_e;

  localparam int BYTE_W      = 8;
  localparam int FRAME_SLOTS = 11;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int READ_FRAMES = 3;
  localparam int FIDX_W      = $clog2(READ_FRAMES);

  localparam logic [BYTE_W-1:0] INS_LOAD   = 8'h4C;
  localparam logic [BYTE_W-1:0] INS_ADDR   = 8'h0C;
  localparam logic [BYTE_W-1:0] INS_FETCH  = 8'h68;
  localparam logic [BYTE_W-1:0] INS_HI_SEL = 8'h10;
  localparam logic [BYTE_W-1:0] DAT_IDRD   = 8'h08;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic [BYTE_W-1:0] instr;
  } hvs_frame_t;

  // slot 0 is the start bit, slots 1..8 carry the byte MSB first, rest stop bits
  function automatic logic frame_bit(input logic [BYTE_W-1:0] b,
                                     input logic [SLOT_W-1:0] slot);
    logic r;
    r = 1'b0;
    if (slot >= SLOT_W'(1) && slot <= SLOT_W'(BYTE_W))
      r = b[BYTE_W - int'(slot)];
    return r;
  endfunction

endpackage

// File: rtl/hvs_phase_gen.sv
module hvs_phase_gen #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/hvs_frame_engine.sv
module hvs_frame_engine
  import hvs_pkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  hvs_frame_t        frame_i,
  input  logic              rdbk,
  output logic              sclk,
  output logic              sdata,
  output logic              sinstr,
  output logic              active,
  output logic              frame_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  logic              tick;
  logic              hi;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] rx_sh;
  hvs_frame_t        cur;

  hvs_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      frame_done <= 1'b0;
      hi         <= 1'b0;
      slot       <= '0;
      sclk       <= 1'b0;
      sdata      <= 1'b0;
      sinstr     <= 1'b0;
      rx_sh      <= '0;
      cur        <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          slot   <= '0;
          hi     <= 1'b0;
          sclk   <= 1'b0;
          cur    <= frame_i;
          sdata  <= frame_bit(frame_i.data, '0);
          sinstr <= frame_bit(frame_i.instr, '0);
          rx_sh  <= '0;
        end
      end else if (tick) begin
        if (!hi) begin
          hi   <= 1'b1;
          sclk <= 1'b1;
          if (slot < SLOT_W'(BYTE_W)) rx_sh <= {rx_sh[BYTE_W-2:0], rdbk};
        end else begin
          hi   <= 1'b0;
          sclk <= 1'b0;
          if (slot == LAST_SLOT) begin
            active     <= 1'b0;
            frame_done <= 1'b1;
            sdata      <= 1'b0;
            sinstr     <= 1'b0;
          end else begin
            slot   <= slot + SLOT_W'(1);
            sdata  <= frame_bit(cur.data, slot + SLOT_W'(1));
            sinstr <= frame_bit(cur.instr, slot + SLOT_W'(1));
          end
        end
      end
    end
  end

  assign rx_byte = rx_sh;

  // R3
  lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> ($stable(sdata) && $stable(sinstr)));

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST_SLOT);

  // R2
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!sdata && !sinstr && !sclk));

endmodule

// File: rtl/hvs_cmd_seq.sv
module hvs_cmd_seq
  import hvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_addr,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] cmd_instr,
  input  logic              frame_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output hvs_frame_t        frame_o,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata
);
  hvs_op_e           op_q;
  logic [1:0]        addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] instr_q;
  logic [FIDX_W-1:0] fidx;
  logic              is_read;
  logic              is_cal;
  logic [FIDX_W-1:0] last_idx;

  assign is_read  = (op_q == OP_SIG) || (op_q == OP_CAL);
  assign is_cal   = (op_q == OP_CAL);
  assign last_idx = is_read ? FIDX_W'(READ_FRAMES - 1) : '0;

  always_comb begin
    frame_o = '{data: data_q, instr: instr_q};
    if (is_read) begin
      case (fidx)
        FIDX_W'(0): frame_o = '{data: DAT_IDRD, instr: INS_LOAD};
        FIDX_W'(1): frame_o = '{data: is_cal ? '0 : {6'b0, addr_q}, instr: INS_ADDR};
        default:    frame_o = '{data: '0,
                                instr: INS_FETCH | (is_cal ? INS_HI_SEL : '0)};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_RAW;
      addr_q  <= '0;
      data_q  <= '0;
      instr_q <= '0;
      fidx    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      start   <= 1'b0;
      rdata   <= '0;
    end else begin
      start <= 1'b0;
      done  <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy    <= 1'b1;
          op_q    <= hvs_op_e'(cmd_op);
          addr_q  <= cmd_addr;
          data_q  <= cmd_data;
          instr_q <= cmd_instr;
          fidx    <= '0;
          start   <= 1'b1;
        end
      end else if (frame_done) begin
        if (fidx == last_idx) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= rx_byte;
        end else begin
          fidx  <= fidx + FIDX_W'(1);
          start <= 1'b1;
        end
      end
    end
  end

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done);

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(addr_q)));

  // R6
  fidx_range_chk: assert property (@(posedge clk) disable iff (rst)
    fidx <= FIDX_W'(READ_FRAMES - 1));

endmodule

// File: rtl/hv_serial_shifter.sv
module hv_serial_shifter #(
  parameter int HALF_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [1:0] cmd_addr,
  input  logic [7:0] cmd_data,
  input  logic [7:0] cmd_instr,
  input  logic       ser_rdbk,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_instr
);
  import hvs_pkg::*;

  logic       start;
  hvs_frame_t frame;
  logic       active;
  logic       frame_done;
  logic [7:0] rx_byte;

  hvs_cmd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_instr  (cmd_instr),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .start      (start),
    .frame_o    (frame),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata)
  );

  hvs_frame_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .frame_i    (frame),
    .rdbk       (ser_rdbk),
    .sclk       (ser_clk),
    .sdata      (ser_data),
    .sinstr     (ser_instr),
    .active     (active),
    .frame_done (frame_done),
    .rx_byte    (rx_byte)
  );

  // R4
  clk_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> busy);

endmodule

// File: tb/hv_serial_shifter_bench.sv
`timescale 1ns/1ps
module hv_serial_shifter_bench;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_addr = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] cmd_instr = 8'h00;
  logic       ser_rdbk;
  logic       busy, done, ser_clk, ser_data, ser_instr;
  logic [7:0] rdata;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  hv_serial_shifter #(.HALF_DIV(HALF)) u_hv_serial_shifter (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_instr(cmd_instr),
    .ser_rdbk(ser_rdbk), .busy(busy), .done(done), .rdata(rdata),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_instr(ser_instr)
  );

  // target model: returns resp[frame] MSB first, then 1s
  logic [7:0]  resp [0:2];
  logic [10:0] got_d [0:3];
  logic [10:0] got_i [0:3];
  logic [10:0] cap_d, cap_i;
  int fc = 0, rc = 0, rises = 0, hi_cyc = 0, busy_cyc = 0;

  function automatic logic model_bit(input int f, input int r);
    logic [7:0] b;
    b = resp[(f > 2) ? 2 : f];
    return (r < 8) ? b[7-r] : 1'b1;
  endfunction

  assign ser_rdbk = model_bit(fc, rc);

  always @(posedge ser_clk) begin
    rises = rises + 1;
    cap_d = {cap_d[9:0], ser_data};
    cap_i = {cap_i[9:0], ser_instr};
    if (rc == 10) begin
      if (fc < 4) begin
        got_d[fc] = cap_d;
        got_i[fc] = cap_i;
      end
      fc = fc + 1;
      rc = 0;
    end else begin
      rc = rc + 1;
    end
  end

  always @(posedge clk) begin
    if (ser_clk) hi_cyc <= hi_cyc + 1;
    if (busy)    busy_cyc <= busy_cyc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2);
    resp[0] = r0; resp[1] = r1; resp[2] = r2;
    fc = 0; rc = 0; rises = 0; cap_d = '0; cap_i = '0;
    for (int i = 0; i < 4; i++) begin got_d[i] = '1; got_i[i] = '1; end
    hi_cyc = 0; busy_cyc = 0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [1:0] addr,
                         input logic [7:0] d, input logic [7:0] ins, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = d; cmd_instr = ins;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " R9 busy after accept"}, busy, 1);
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    chk({req, " R9 done seen"}, done, 1);
    chk({req, " R9 busy low with done"}, busy, 0);
    @(negedge clk);
    chk({req, " R9 done is a pulse"}, done, 0);
    chk({req, " R4 clock idles low"}, ser_clk, 0);
  endtask

  function automatic logic [10:0] fr(input logic [7:0] b);
    return {1'b0, b, 2'b00};
  endfunction

  task automatic t_reset;
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 ser_data", ser_data, 0);
    chk("R1 ser_instr", ser_instr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rdata", rdata, 8'h00);
  endtask

  task automatic t_raw(input logic [1:0] op, input logic [7:0] d, input logic [7:0] ins,
                       input logic [7:0] r);
    clear_model(r, 8'hFF, 8'hFF);
    run_cmd(op, 2'b00, d, ins, "R11");
    chk("R11 one frame", fc, 1);
    chk("R2 R11 data frame", got_d[0], fr(d));
    chk("R2 R11 instr frame", got_i[0], fr(ins));
    chk("R5 raw result", rdata, r);
    chk("R4 rises per frame", rises, 11);
    chk("R4 high cycles", hi_cyc, 11*HALF);
    chk("R4 busy window", busy_cyc, 22*HALF+2);
  endtask

  task automatic t_sig(input logic [1:0] a, input logic [7:0] r);
    clear_model(8'hA5, 8'h5A, r);
    run_cmd(2'b01, a, 8'h00, 8'h00, "R6");
    chk("R6 three frames", fc, 3);
    chk("R6 f0 data", got_d[0], fr(8'h08));
    chk("R6 f0 instr", got_i[0], fr(8'h4C));
    chk("R6 f1 data addr", got_d[1], fr({6'b0, a}));
    chk("R6 f1 instr", got_i[1], fr(8'h0C));
    chk("R6 f2 data", got_d[2], fr(8'h00));
    chk("R6 f2 instr", got_i[2], fr(8'h68));
    chk("R8 R5 result from last frame", rdata, r);
  endtask

  task automatic t_cal(input logic [7:0] r);
    clear_model(8'h33, 8'hCC, r);
    run_cmd(2'b10, 2'b11, 8'h00, 8'h00, "R7");
    chk("R7 three frames", fc, 3);
    chk("R7 f0 instr", got_i[0], fr(8'h4C));
    chk("R7 f1 data", got_d[1], fr(8'h00));
    chk("R7 f2 instr selector", got_i[2], fr(8'h78));
    chk("R8 cal result", rdata, r);
  endtask

  task automatic t_busy_ignore;
    clear_model(8'h11, 8'h22, 8'h96);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 2'b10;
    @(negedge clk);
    cmd_op = 2'b00; cmd_data = 8'hF0; cmd_instr = 8'h0F;
    for (int i = 0; i < 20; i++) @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    chk("R10 result unchanged", rdata, 8'h96);
    chk("R10 addr kept", got_d[1], fr(8'h02));
    for (int i = 0; i < 100; i++) @(negedge clk);
    chk("R10 no extra frame", fc, 3);
    chk("R10 idle after", busy, 0);
  endtask

  initial begin
    #(10*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    clear_model(8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_raw(2'b00, 8'hB4, 8'h3C, 8'hC3);
    t_raw(2'b11, 8'h81, 8'h7E, 8'h01);
    t_sig(2'b00, 8'h1E);
    t_sig(2'b01, 8'h92);
    t_sig(2'b10, 8'h06);
    t_cal(8'h6D);
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule